// File: doc/BRIEF.md
# Two-Bank Fetch Alignment Unit

This unit builds one fetch group per cycle from an instruction cache split into an even bank and an odd bank of lines. A fetch address (an instruction index) names two consecutive lines, one from each bank. The unit drives the row address of each bank and receives both lines together with per-slot branch flags and branch targets. It also receives a small vector of predicted directions, one for each branch in the group in order.

The two lines are swapped into program order when the fetch address lies in an odd-bank line. The resulting 16-instruction window is shifted left so that the addressed instruction sits in slot 0. Every slot past the first limit reached is masked off. The limits are the first predicted-taken branch (which is kept), the third branch of the group, and the end of the second line. One cycle after a fetch request the output latch holds the aligned slots, a valid vector and the address for the next fetch.

Top module: `fetch_align`

## Requirements
- R1: After reset, grp_valid_o is 0, slot_valid_o is all zeros and next_addr_o is 0.
- R2: odd_row_o equals fetch_addr_i[AW-1:4], and even_row_o equals fetch_addr_i[AW-1:4] plus fetch_addr_i[3], combinationally (8 instructions per line, bit 3 picks the bank).
- R3: When fetch_addr_i[3] is 1, the odd-bank line supplies the first instructions of the group and the even-bank line follows.
- R4: One cycle after fetch_valid_i is high, grp_valid_o is 1 and slot k holds the instruction at address fetch_addr_i + k for every valid slot. Slot 0 is always valid.
- R5: Slots with k >= 16 - fetch_addr_i[2:0] are invalid even when no branch limit is reached.
- R6: The first branch predicted taken ends the group. It is valid itself, and all later slots are invalid.
- R7: A branch predicted not-taken does not end the group. The j-th branch of the group (counting from 0) takes its direction from pred_taken_i[j], where 1 means taken.
- R8: A group holds at most 3 branches. The third branch is the last valid slot.
- R9: next_addr_o is the target of the ending taken branch. Without one, it is fetch_addr_i plus the number of valid slots.
- R10: The valid slots form a contiguous prefix of slot_valid_o, and every invalid slot has slot_insn_o equal to zero.
- R11: One cycle after fetch_valid_i is low, grp_valid_o is 0 and slot_valid_o, slot_insn_o and next_addr_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch request this cycle |
| fetch_addr_i | input | AW | Instruction index of the first instruction |
| pred_taken_i | input | MAX_BR | Predicted direction per branch, bit 0 first |
| even_row_o | output | AW-4 | Row read from the even bank |
| odd_row_o | output | AW-4 | Row read from the odd bank |
| bank_even_insn_i | input | LINE*IW | Even-bank line, slot 0 in the low bits |
| bank_even_br_i | input | LINE | Even-bank per-slot branch flags |
| bank_even_tgt_i | input | LINE*AW | Even-bank per-slot branch targets |
| bank_odd_insn_i | input | LINE*IW | Odd-bank line, slot 0 in the low bits |
| bank_odd_br_i | input | LINE | Odd-bank per-slot branch flags |
| bank_odd_tgt_i | input | LINE*AW | Odd-bank per-slot branch targets |
| grp_valid_o | output | 1 | Latch holds a fresh group |
| slot_insn_o | output | 2*LINE*IW | Aligned instructions, slot 0 in the low bits |
| slot_valid_o | output | 2*LINE | Per-slot valid |
| next_addr_o | output | AW | Next fetch address |

## Verification
The assertions check on every cycle that the valid vector is a contiguous prefix starting at slot 0, that it never reaches past the end of the two-line window, and that no group carries more than three branches. They also check that a group ended by a taken prediction finishes on a branch, and that an idle cycle leaves the latch unchanged. The bench scenarios alone show the interchange order, the exact instruction in each slot, which branch reads which prediction bit, and the next address in its sequential and taken forms.

// File: rtl/fetch_align_pkg.sv
package fetch_align_pkg;
  typedef enum logic [1:0] {
    END_WINDOW   = 2'd0,
    END_TAKEN    = 2'd1,
    END_BR_LIMIT = 2'd2
  } grp_end_e;
endpackage

// File: rtl/bank_xchg.sv
module bank_xchg #(
  parameter int W = 8
) (
  input  logic         swap_i,
  input  logic [W-1:0] even_i,
  input  logic [W-1:0] odd_i,
  output logic [W-1:0] first_o,
  output logic [W-1:0] second_o
);
  assign first_o  = swap_i ? odd_i  : even_i;
  assign second_o = swap_i ? even_i : odd_i;
endmodule

// File: rtl/align_shift.sv
module align_shift #(
  parameter int SLOTS = 16,
  parameter int EW    = 8,
  parameter int OFF_W = 3
) (
  input  logic [SLOTS*EW-1:0] win_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [SLOTS*EW-1:0] slot_o,
  output logic [SLOTS-1:0]    avail_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      int idx;
      idx = k + int'(off_i);
      if (idx < SLOTS) begin
        slot_o[k*EW +: EW] = win_i[idx*EW +: EW];
        avail_o[k]         = 1'b1;
      end else begin
        slot_o[k*EW +: EW] = '0;
        avail_o[k]         = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetch_limit.sv
module fetch_limit
  import fetch_align_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int MAX_BR = 3,
  parameter int AW     = 32,
  localparam int NV_W  = $clog2(SLOTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SLOTS-1:0]    avail_i,
  input  logic [SLOTS-1:0]    br_i,
  input  logic [SLOTS*AW-1:0] tgt_i,
  input  logic [MAX_BR-1:0]   pred_i,
  output logic [SLOTS-1:0]    valid_o,
  output grp_end_e            end_o,
  output logic [AW-1:0]       tgt_o,
  output logic [NV_W-1:0]     n_valid_o
);
  always_comb begin
    int  cnt;
    logic stop;
    cnt       = 0;
    stop      = 1'b0;
    valid_o   = '0;
    end_o     = END_WINDOW;
    tgt_o     = '0;
    n_valid_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (avail_i[k] && !stop) begin
        valid_o[k] = 1'b1;
        n_valid_o  = n_valid_o + 1'b1;
        if (br_i[k]) begin
          if (cnt < MAX_BR && pred_i[cnt]) begin
            stop  = 1'b1;
            end_o = END_TAKEN;
            tgt_o = tgt_i[k*AW +: AW];
          end
          cnt = cnt + 1;
          if (cnt >= MAX_BR && !stop) begin
            stop  = 1'b1;
            end_o = END_BR_LIMIT;
          end
        end
      end
    end
  end

  logic [SLOTS-1:0] last_slot;
  assign last_slot = valid_o & ~(valid_o >> 1);

  p_br_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_o & br_i) <= MAX_BR);

  p_taken_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o == END_TAKEN) |-> ($onehot0(last_slot) && ((last_slot & br_i) != '0)));
endmodule

// File: rtl/fetch_align.sv
module fetch_align
  import fetch_align_pkg::*;
#(
  parameter int IW     = 32,
  parameter int AW     = 32,
  parameter int LINE   = 8,
  parameter int MAX_BR = 3,
  localparam int OFF_W = $clog2(LINE),
  localparam int RW    = AW - OFF_W - 1,
  localparam int WIN   = 2 * LINE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_valid_i,
  input  logic [AW-1:0]       fetch_addr_i,
  input  logic [MAX_BR-1:0]   pred_taken_i,
  output logic [RW-1:0]       even_row_o,
  output logic [RW-1:0]       odd_row_o,
  input  logic [LINE*IW-1:0]  bank_even_insn_i,
  input  logic [LINE-1:0]     bank_even_br_i,
  input  logic [LINE*AW-1:0]  bank_even_tgt_i,
  input  logic [LINE*IW-1:0]  bank_odd_insn_i,
  input  logic [LINE-1:0]     bank_odd_br_i,
  input  logic [LINE*AW-1:0]  bank_odd_tgt_i,
  output logic                grp_valid_o,
  output logic [WIN*IW-1:0]   slot_insn_o,
  output logic [WIN-1:0]      slot_valid_o,
  output logic [AW-1:0]       next_addr_o
);
  localparam int EW   = IW + 1 + AW;
  localparam int NV_W = $clog2(WIN + 1);

  logic [OFF_W-1:0] off;
  logic             odd_first;
  logic [RW-1:0]    base_row;

  assign off        = fetch_addr_i[OFF_W-1:0];
  assign odd_first  = fetch_addr_i[OFF_W];
  assign base_row   = fetch_addr_i[AW-1:OFF_W+1];
  assign odd_row_o  = base_row;
  assign even_row_o = base_row + RW'(odd_first);

  // slot entry: {target, branch flag, instruction}
  logic [LINE*EW-1:0] even_pack, odd_pack, first_line, second_line;
  for (genvar j = 0; j < LINE; j++) begin : g_pack
    assign even_pack[j*EW +: EW] = {bank_even_tgt_i[j*AW +: AW], bank_even_br_i[j],
                                    bank_even_insn_i[j*IW +: IW]};
    assign odd_pack[j*EW +: EW]  = {bank_odd_tgt_i[j*AW +: AW], bank_odd_br_i[j],
                                    bank_odd_insn_i[j*IW +: IW]};
  end

  bank_xchg #(.W(LINE*EW)) u_xchg (
    .swap_i   (odd_first),
    .even_i   (even_pack),
    .odd_i    (odd_pack),
    .first_o  (first_line),
    .second_o (second_line)
  );

  logic [WIN*EW-1:0] win, slots;
  logic [WIN-1:0]    avail;
  assign win = {second_line, first_line};

  align_shift #(.SLOTS(WIN), .EW(EW), .OFF_W(OFF_W)) u_shift (
    .win_i   (win),
    .off_i   (off),
    .slot_o  (slots),
    .avail_o (avail)
  );

  logic [WIN*IW-1:0] s_insn;
  logic [WIN-1:0]    s_br;
  logic [WIN*AW-1:0] s_tgt;
  for (genvar k = 0; k < WIN; k++) begin : g_unpack
    assign s_insn[k*IW +: IW] = slots[k*EW +: IW];
    assign s_br[k]            = slots[k*EW + IW];
    assign s_tgt[k*AW +: AW]  = slots[k*EW + IW + 1 +: AW];
  end

  logic [WIN-1:0]  lim_valid;
  grp_end_e        lim_end;
  logic [AW-1:0]   lim_tgt;
  logic [NV_W-1:0] lim_n;

  fetch_limit #(.SLOTS(WIN), .MAX_BR(MAX_BR), .AW(AW)) u_limit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .avail_i   (avail),
    .br_i      (s_br),
    .tgt_i     (s_tgt),
    .pred_i    (pred_taken_i),
    .valid_o   (lim_valid),
    .end_o     (lim_end),
    .tgt_o     (lim_tgt),
    .n_valid_o (lim_n)
  );

  logic [WIN*IW-1:0] masked_insn;
  for (genvar k = 0; k < WIN; k++) begin : g_mask
    assign masked_insn[k*IW +: IW] = s_insn[k*IW +: IW] & {IW{lim_valid[k]}};
  end

  logic [AW-1:0] next_c;
  assign next_c = (lim_end == END_TAKEN) ? lim_tgt : fetch_addr_i + AW'(lim_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_valid_o  <= 1'b0;
      slot_insn_o  <= '0;
      slot_valid_o <= '0;
      next_addr_o  <= '0;
    end else if (fetch_valid_i) begin
      grp_valid_o  <= 1'b1;
      slot_insn_o  <= masked_insn;
      slot_valid_o <= lim_valid;
      next_addr_o  <= next_c;
    end else begin
      grp_valid_o  <= 1'b0;
    end
  end

  p_slot0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> slot_valid_o[0]);

  p_prefix_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> ((slot_valid_o & (slot_valid_o + 1'b1)) == '0));

  p_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> ($countones(slot_valid_o) <= WIN - int'($past(off))));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> (!grp_valid_o && $stable(slot_valid_o) && $stable(next_addr_o)));
endmodule

// File: tb/fetch_align_tb_top.sv
module fetch_align_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 32, AW = 32, LINE = 8, MAX_BR = 3;
  localparam int WIN = 2 * LINE;
  localparam int RW = AW - 4;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                fetch_valid;
  logic [AW-1:0]       fetch_addr;
  logic [MAX_BR-1:0]   pred;
  logic [RW-1:0]       even_row, odd_row;
  logic [LINE*IW-1:0]  e_insn, o_insn;
  logic [LINE-1:0]     e_br, o_br;
  logic [LINE*AW-1:0]  e_tgt, o_tgt;
  logic                grp_valid;
  logic [WIN*IW-1:0]   slot_insn;
  logic [WIN-1:0]      slot_valid;
  logic [AW-1:0]       next_addr;

  logic [255:0] br_map;
  int checks = 0, errors = 0;

  function automatic logic [IW-1:0] word_at(int a);
    return 32'hC000_0000 | 32'(a);
  endfunction
  function automatic logic [AW-1:0] tgt_at(int a);
    return 32'(a + 100);
  endfunction

  // behavioural banks: even line 2*row, odd line 2*row+1
  always_comb begin
    for (int j = 0; j < LINE; j++) begin
      int ea, oa;
      ea = int'(even_row) * 16 + j;
      oa = int'(odd_row) * 16 + 8 + j;
      e_insn[j*IW +: IW] = word_at(ea);
      o_insn[j*IW +: IW] = word_at(oa);
      e_br[j] = br_map[ea[7:0]];
      o_br[j] = br_map[oa[7:0]];
      e_tgt[j*AW +: AW] = tgt_at(ea);
      o_tgt[j*AW +: AW] = tgt_at(oa);
    end
  end

  fetch_align #(.IW(IW), .AW(AW), .LINE(LINE), .MAX_BR(MAX_BR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr), .pred_taken_i(pred),
    .even_row_o(even_row), .odd_row_o(odd_row),
    .bank_even_insn_i(e_insn), .bank_even_br_i(e_br), .bank_even_tgt_i(e_tgt),
    .bank_odd_insn_i(o_insn), .bank_odd_br_i(o_br), .bank_odd_tgt_i(o_tgt),
    .grp_valid_o(grp_valid), .slot_insn_o(slot_insn), .slot_valid_o(slot_valid),
    .next_addr_o(next_addr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_wide(string req, logic [WIN*IW-1:0] act, logic [WIN*IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference group built from the requirements
  task automatic fetch_and_check(string req, int a, logic [MAX_BR-1:0] p);
    logic [WIN-1:0]    ev;
    logic [WIN*IW-1:0] ei;
    logic [AW-1:0]     en;
    int off, cnt, n;
    logic stop, tk;
    off = a % 8; cnt = 0; n = 0; stop = 0; tk = 0; ev = '0; ei = '0; en = '0;
    for (int k = 0; k < WIN; k++) begin
      if (k < WIN - off && !stop) begin
        ev[k] = 1'b1;
        ei[k*IW +: IW] = word_at(a + k);
        n++;
        if (br_map[8'(a + k)]) begin
          if (p[cnt]) begin stop = 1; tk = 1; en = tgt_at(a + k); end
          cnt++;
          if (cnt == MAX_BR) stop = 1;
        end
      end
    end
    if (!tk) en = 32'(a + n);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 32'(a); pred = p;
    #1;
    check({req, " R2 odd row"}, 64'(odd_row), 64'(a / 16));
    check({req, " R2 even row"}, 64'(even_row), 64'(a / 16 + ((a / 8) % 2)));
    @(negedge clk);
    fetch_valid = 1'b0;
    check({req, " R4 grp_valid"}, 64'(grp_valid), 64'd1);
    check({req, " valid vector R10"}, 64'(slot_valid), 64'(ev));
    check_wide({req, " slot contents R4 R10"}, slot_insn, ei);
    check({req, " R9 next address"}, 64'(next_addr), 64'(en));
  endtask

  task automatic t_reset_r1();
    check("R1 grp_valid", 64'(grp_valid), 64'd0);
    check("R1 slot_valid", 64'(slot_valid), 64'd0);
    check("R1 next_addr", 64'(next_addr), 64'd0);
  endtask

  task automatic t_aligned_r4();
    br_map = '0;
    fetch_and_check("R4 aligned even-first", 16, 3'b000);
    check("R4 next seq", 64'(next_addr), 64'd32);
  endtask

  task automatic t_interchange_r3();
    br_map = '0;
    fetch_and_check("R3 odd-first off3", 11, 3'b000);
    check("R3 count", 64'($countones(slot_valid)), 64'd13);
    fetch_and_check("R3 odd-first off2", 26, 3'b111);
  endtask

  task automatic t_window_end_r5();
    br_map = '0;
    fetch_and_check("R5 off7", 7, 3'b000);
    check("R5 nine slots", 64'(slot_valid), 64'h01FF);
  endtask

  task automatic t_taken_r6();
    br_map = '0; br_map[22] = 1'b1;
    fetch_and_check("R6 taken", 18, 3'b001);
    check("R6 ends at branch", 64'(slot_valid), 64'h001F);
  endtask

  task automatic t_not_taken_r7();
    br_map = '0; br_map[34] = 1'b1; br_map[37] = 1'b1;
    fetch_and_check("R7 second taken", 32, 3'b010);
    check("R7 next target", 64'(next_addr), 64'd137);
    fetch_and_check("R7 none taken", 32, 3'b100);
    check("R7 runs past", 64'(slot_valid), 64'hFFFF);
  endtask

  task automatic t_br_limit_r8();
    br_map = '0; br_map[41] = 1; br_map[43] = 1; br_map[45] = 1; br_map[47] = 1;
    fetch_and_check("R8 branch limit", 40, 3'b000);
    check("R8 six slots", 64'(slot_valid), 64'h003F);
  endtask

  task automatic t_idle_r11();
    logic [WIN-1:0]    v;
    logic [WIN*IW-1:0] ins;
    logic [AW-1:0]     na;
    v = slot_valid; ins = slot_insn; na = next_addr;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = 32'd3; pred = 3'b111;
    @(negedge clk);
    check("R11 grp_valid low", 64'(grp_valid), 64'd0);
    check("R11 valid held", 64'(slot_valid), 64'(v));
    check_wide("R11 slots held", slot_insn, ins);
    check("R11 next held", 64'(next_addr), 64'(na));
  endtask

  initial begin
    fetch_valid = 0; fetch_addr = '0; pred = '0; br_map = '0;
    #(CLK_PERIOD*2 + 2);
    t_reset_r1();
    rst_n = 1;
    t_aligned_r4();
    t_interchange_r3();
    t_window_end_r5();
    t_taken_r6();
    t_not_taken_r7();
    t_br_limit_r8();
    t_idle_r11();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule